// File: doc/BRIEF.md
# Colour Block Test Pattern Generator

This block paints a procedural test image for a display pipeline. A separate sync timing generator supplies the pixel coordinate, an active-video flag and a pixel strobe. From these the block works out which cell of an 8x8 grid the pixel falls in, over a 256-pixel by 240-row logical image. It then drives a 6-bit colour word with two bits each for red, green and blue. Each cell is a solid colour. The colour code counts down by one from cell to cell, so all 64 codes appear exactly once, starting from white in the top-left corner.

A second mode isolates a single cell, which is useful for judging whether a colour looks the same in different parts of the screen. The chosen cell is filled white and every other pixel is black, and the cell can be moved by changing its column and row inputs. Outside active video the output is always black, because the monitor expects no drive during blanking. The output is registered and only changes on strobe cycles, so it lags the coordinate by exactly one pixel.

Top module: `tpat_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, rgb_o is 0.
- R2: On a strobe cycle with active_i low, the next rgb_o is 0 whatever the coordinate or mode.
- R3: The column is x_i/32 and the row is y_i/30 (integer division). The colour code is 63 - (row*8 + column). rgb_o[5:4] is red, rgb_o[3:2] is green and rgb_o[1:0] is blue, with the upper bit of each pair weighted double.
- R4: The top-left cell shows 6'h3F (white) and the bottom-right cell shows 6'h00. Moving one cell right lowers the code by 1, and moving one row down lowers it by 8.
- R5: With mask_en_i high, a pixel inside the cell at cell_col_i, cell_row_i gives 6'h3F and any other active pixel gives 0.
- R6: rgb_o updates only at a clock edge where pix_stb_i is high. It reflects the inputs sampled at that edge and holds its value through cycles with pix_stb_i low.
- R7: An active pixel with y_i of 240 or more is drawn black.
- R8: Cell edges fall exactly on the pixel grid: x_i 31 is column 0 and x_i 32 is column 1; y_i 29 is row 0 and y_i 30 is row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_stb_i | input | 1 | Pixel strobe; one pixel per high cycle |
| active_i | input | 1 | Position lies in active video |
| x_i | input | 8 | Horizontal pixel coordinate, 0..255 |
| y_i | input | 8 | Logical row coordinate, 0..239 |
| mask_en_i | input | 1 | Single-cell isolation mode |
| cell_col_i | input | 3 | Column of the isolated cell |
| cell_row_i | input | 3 | Row of the isolated cell |
| rgb_o | output | 6 | Registered colour {red, green, blue}, 2 bits each |

## Verification
A sweep over the centre of all 64 cells shows that the descending code, the row*8+column indexing and the bit layout are all right, since any swap of row and column or any ascending count gives a different value in most cells. Pixels placed one side or the other of each cell edge show whether the division by 32 and by 30 is off by one. The mask mode is tried with the isolated cell at a corner, at an interior position, and after the cell has been moved, which shows that only the selected cell lights. Further tests drive blanking, rows past the image, and idle strobe cycles with changing inputs, and these show that blanking has priority and that the output register holds.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
  localparam int unsigned COMP_W  = 2;
  localparam int unsigned RGB_W   = 3 * COMP_W;
  localparam int unsigned GRID    = 8;
  localparam int unsigned IDX_W   = $clog2(GRID);
  localparam int unsigned X_W     = 8;
  localparam int unsigned Y_W     = 8;
  localparam int unsigned IMG_W   = 256;
  localparam int unsigned IMG_H   = 240;
  localparam int unsigned CELL_W  = IMG_W / GRID;
  localparam int unsigned CELL_H  = IMG_H / GRID;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] grn;
    logic [COMP_W-1:0] blu;
  } rgb_t;
endpackage

// File: rtl/tpat_band.sv
// Maps a coordinate to its cell index by comparison against cell edges.
module tpat_band #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned SPAN  = 32,
  parameter int unsigned COUNT = 8,
  localparam int unsigned IW   = $clog2(COUNT)
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [IW-1:0]    idx_o,
  output logic             inside_o
);
  logic [31:0] val_ext;
  assign val_ext  = 32'(val_i);
  assign inside_o = val_ext < 32'(SPAN * COUNT);

  always_comb begin
    idx_o = '0;
    for (int k = 1; k < int'(COUNT); k++) begin
      if (val_ext >= 32'(k * int'(SPAN))) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/tpat_shade.sv
// Chooses the colour code for one cell in grid or isolation mode.
module tpat_shade
  import tpat_pkg::*;
(
  input  logic [IDX_W-1:0] col_i,
  input  logic [IDX_W-1:0] row_i,
  input  logic             mask_en_i,
  input  logic [IDX_W-1:0] sel_col_i,
  input  logic [IDX_W-1:0] sel_row_i,
  output logic [RGB_W-1:0] code_o
);
  localparam logic [RGB_W-1:0] WHITE = '1;

  logic [RGB_W-1:0] cell_idx;
  logic             hit;

  assign cell_idx = RGB_W'({row_i, col_i});
  assign hit      = (col_i == sel_col_i) && (row_i == sel_row_i);

  always_comb begin
    if (mask_en_i) code_o = hit ? WHITE : '0;
    else           code_o = WHITE - cell_idx;
  end
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
  import tpat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_stb_i,
  input  logic             active_i,
  input  logic [7:0]       x_i,
  input  logic [7:0]       y_i,
  input  logic             mask_en_i,
  input  logic [2:0]       cell_col_i,
  input  logic [2:0]       cell_row_i,
  output logic [5:0]       rgb_o
);
  logic [IDX_W-1:0] col, row;
  logic             in_x, in_y;
  logic [RGB_W-1:0] code;
  rgb_t             pix_d, pix_q;

  tpat_band #(.VAL_W(X_W), .SPAN(CELL_W), .COUNT(GRID)) u_col (
    .val_i(x_i), .idx_o(col), .inside_o(in_x)
  );

  tpat_band #(.VAL_W(Y_W), .SPAN(CELL_H), .COUNT(GRID)) u_row (
    .val_i(y_i), .idx_o(row), .inside_o(in_y)
  );

  tpat_shade u_shade (
    .col_i(col), .row_i(row), .mask_en_i(mask_en_i),
    .sel_col_i(cell_col_i), .sel_row_i(cell_row_i), .code_o(code)
  );

  // blanking overrides everything
  assign pix_d = (active_i && in_x && in_y) ? rgb_t'(code) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pix_q <= '0;
    else if (pix_stb_i) pix_q <= pix_d;
  end

  assign rgb_o = pix_q;
endmodule

// File: rtl/tpat_gen_chk.sv
module tpat_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pix_stb_i,
  input logic       active_i,
  input logic [7:0] y_i,
  input logic       mask_en_i,
  input logic [5:0] rgb_o
);
  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset_black: assert (rgb_o == 6'h00);
  end

  a_r2_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_stb_i && !active_i) |=> (rgb_o == 6'h00));

  a_r5_mask_two_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_stb_i && mask_en_i) |=> (rgb_o == 6'h00 || rgb_o == 6'h3F));

  a_r6_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_stb_i |=> $stable(rgb_o));

  a_r7_below_image_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_stb_i && y_i >= 8'd240) |=> (rgb_o == 6'h00));
endmodule

bind tpat_gen tpat_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_stb_i(pix_stb_i), .active_i(active_i),
  .y_i(y_i), .mask_en_i(mask_en_i), .rgb_o(rgb_o)
);

// File: tb/tpat_gen_tb.sv
module tpat_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pix_stb_i = 1'b0;
  logic       active_i = 1'b0;
  logic [7:0] x_i = '0;
  logic [7:0] y_i = '0;
  logic       mask_en_i = 1'b0;
  logic [2:0] cell_col_i = '0;
  logic [2:0] cell_row_i = '0;
  logic [5:0] rgb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tpat_gen u_dut (.*);

  function automatic logic [5:0] model(input int x, input int y, input bit act,
                                       input bit msk, input int sc, input int sr);
    int col = x / 32;
    int row = y / 30;
    if (!act || y >= 240) return 6'h00;
    if (msk) return (col == sc && row == sr) ? 6'h3F : 6'h00;
    return 6'(63 - (row * 8 + col));
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rgb_o=%h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge with strobe, sample at following negedge
  task automatic pixel(input int x, input int y, input bit act, input string req);
    @(negedge clk_i);
    x_i = 8'(x); y_i = 8'(y); active_i = act; pix_stb_i = 1'b1;
    @(negedge clk_i);
    pix_stb_i = 1'b0;
    check(req, rgb_o, model(x, y, act, mask_en_i, int'(cell_col_i), int'(cell_row_i)));
  endtask

  task automatic t_reset();
    #3ns;
    check("R1 in reset", rgb_o, 6'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    x_i = 8'd5; y_i = 8'd5; active_i = 1'b1;
    @(negedge clk_i);
    check("R1 after release no strobe", rgb_o, 6'h00);
  endtask

  task automatic t_grid();
    mask_en_i = 1'b0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        pixel(c * 32 + 16, r * 30 + 15, 1'b1, "R3 cell code");
    pixel(0, 0, 1'b1, "R4 top-left white");
    check("R4 top-left value", rgb_o, 6'h3F);
    pixel(255, 239, 1'b1, "R4 bottom-right black");
    check("R4 bottom-right value", rgb_o, 6'h00);
    pixel(40, 0, 1'b1, "R4 one right");
    check("R4 step right", rgb_o, 6'h3E);
    pixel(0, 30, 1'b1, "R4 one down");
    check("R4 step down", rgb_o, 6'h37);
    // R3 field order: cell (col 5,row 3) -> 63-29=34 = red 2, green 0, blue 2
    pixel(5 * 32, 3 * 30, 1'b1, "R3 layout");
    check("R3 red field", {4'h0, rgb_o[5:4]}, 6'd2);
    check("R3 green field", {4'h0, rgb_o[3:2]}, 6'd0);
    check("R3 blue field", {4'h0, rgb_o[1:0]}, 6'd2);
  endtask

  task automatic t_edges();
    pixel(31, 0, 1'b1, "R8 x=31");
    pixel(32, 0, 1'b1, "R8 x=32");
    pixel(0, 29, 1'b1, "R8 y=29");
    pixel(0, 30, 1'b1, "R8 y=30");
    pixel(223, 209, 1'b1, "R8 x=223 y=209");
    pixel(224, 210, 1'b1, "R8 x=224 y=210");
  endtask

  task automatic t_blank();
    pixel(0, 0, 1'b1, "R2 setup");
    pixel(0, 0, 1'b0, "R2 inactive top-left");
    mask_en_i = 1'b1; cell_col_i = 3'd0; cell_row_i = 3'd0;
    pixel(3, 3, 1'b0, "R2 inactive in mask cell");
    mask_en_i = 1'b0;
  endtask

  task automatic t_rows_past();
    pixel(100, 240, 1'b1, "R7 y=240");
    pixel(0, 255, 1'b1, "R7 y=255");
    mask_en_i = 1'b1; cell_col_i = 3'd0; cell_row_i = 3'd7;
    pixel(0, 245, 1'b1, "R7 mask below image");
    mask_en_i = 1'b0;
  endtask

  task automatic t_mask();
    mask_en_i = 1'b1; cell_col_i = 3'd3; cell_row_i = 3'd4;
    pixel(3 * 32 + 1, 4 * 30 + 1, 1'b1, "R5 selected cell");
    check("R5 selected white", rgb_o, 6'h3F);
    pixel(4 * 32, 4 * 30, 1'b1, "R5 neighbour right");
    pixel(3 * 32, 3 * 30 + 29, 1'b1, "R5 neighbour above");
    pixel(0, 0, 1'b1, "R5 top-left off");
    cell_col_i = 3'd7; cell_row_i = 3'd7;
    pixel(255, 239, 1'b1, "R5 moved to corner");
    pixel(3 * 32 + 1, 4 * 30 + 1, 1'b1, "R5 old cell now dark");
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        pixel(c * 32 + 7, r * 30 + 7, 1'b1, "R5 sweep");
    mask_en_i = 1'b0;
  endtask

  task automatic t_hold();
    logic [5:0] held;
    pixel(40, 40, 1'b1, "R6 load");
    held = rgb_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      x_i = 8'(i * 60); y_i = 8'(i * 50); active_i = i[0];
      mask_en_i = i[1];
      @(negedge clk_i);
      check("R6 hold without strobe", rgb_o, held);
    end
    mask_en_i = 1'b0;
    // latency: value appears only after the strobe edge
    @(negedge clk_i);
    x_i = 8'd0; y_i = 8'd0; active_i = 1'b1; pix_stb_i = 1'b1;
    #1ns;
    check("R6 not yet updated", rgb_o, held);
    @(negedge clk_i);
    pix_stb_i = 1'b0;
    check("R6 updated after strobe", rgb_o, 6'h3F);
  endtask

  initial begin
    t_reset();
    t_grid();
    t_edges();
    t_blank();
    t_rows_past();
    t_mask();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule